// File: doc/BRIEF.md
# 64B/66B Block Payload Scrambler Pair

This block holds the two scrambling datapaths of a 10 Gb/s-class 64B/66B coding layer. The transmit lane takes one 66-bit block per valid cycle. It leaves the 2-bit sync header untouched and whitens the 64-bit payload with a self-synchronizing scrambler whose polynomial is x^58 + x^39 + 1. The receive lane undoes the transform. It needs no seed shared with the far end, because its 58-bit history is filled from the line bits it receives.

All 64 payload bits go through the unrolled recurrence in a single clock. Bit 0 is processed first, so it is the oldest bit in time. Each lane registers its result and presents it one clock after the input. Both lanes start from an all-ones history. A lane's history moves only on cycles where its valid input is high.

Top module: `blk66_scrambler_pair`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both lanes output valid low and an all-zero block. Each lane's 58-bit history starts as all ones.
- R2: A block carries its sync header in bits [65:64] and its payload in bits [63:0]. Both lanes copy the header to their output without change.
- R3: The transmit lane walks the payload from bit 0 to bit 63. For each bit it outputs c = d XOR s(n-39) XOR s(n-58), where s(n-k) is the scrambled bit produced k bit-times earlier. Before the first block, every earlier bit counts as 1.
- R4: The receive lane outputs p = r XOR r(n-39) XOR r(n-58), where r(n-k) is the received line bit from k bit-times earlier. Before the first block, every earlier bit counts as 1. A stream produced under R3 is therefore recovered exactly.
- R5: An output block and its valid appear in the clock after the input block is accepted. Output valid equals input valid delayed by one clock.
- R6: A cycle with valid low does not advance a lane's history. The next valid block is processed as if the idle cycles had never happened.
- R7: Once the receive lane has taken in one full block from a scrambled stream, it recovers the next block exactly, whatever scrambler history produced the stream.
- R8: A single line bit flipped at payload position k corrupts exactly three recovered bits: position k, position k+39 and position k+58, where positions past 63 fall into the next block.
- R9: While its valid input is low, a lane keeps its last output block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both lanes |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid_i | input | 1 | Transmit block present |
| tx_block_i | input | 66 | Transmit block: header [65:64], plain payload [63:0] |
| tx_valid_o | output | 1 | Scrambled block present |
| tx_block_o | output | 66 | Header and scrambled payload |
| rx_valid_i | input | 1 | Received block present |
| rx_block_i | input | 66 | Header and scrambled payload from the line |
| rx_valid_o | output | 1 | Recovered block present |
| rx_block_o | output | 66 | Header and recovered payload |

## Verification
The bench targets the seams of the recurrence and the states a wrong design would reach there.

- **Tap indices.** An off-by-one tap still gives a plausible-looking random payload, but it departs from the model from the first block after the all-ones start.
- **Descrambler feedback.** A receive lane that feeds back its own output instead of the line bit decodes clean loopback data wrongly. It also fails to recover after a foreign history.
- **Single-bit error.** A wrong feedback source shows up as an error count other than three, or as errors at the wrong positions across the block boundary.
- **Idle cycles.** A lane that advances on idle cycles, or lets its output change then, breaks the first block after a gap.

// File: rtl/blk66_scr_pkg.sv
package blk66_scr_pkg;
  parameter int HDR_W   = 2;
  parameter int PAY_W   = 64;
  parameter int STATE_W = 58;
  parameter int TAP_NEAR = 38;
  parameter int TAP_FAR  = STATE_W - 1;
  localparam int BLK_W  = HDR_W + PAY_W;

  typedef struct packed {
    logic [STATE_W-1:0] state;
    logic [PAY_W-1:0]   data;
  } lfsr_res_t;

  // Runs the recurrence over every payload bit, oldest (bit 0) first.
  // feed_line selects whether the incoming bit (descramble) or the produced
  // bit (scramble) is shifted into the history.
  function automatic lfsr_res_t lfsr_run(input logic [STATE_W-1:0] st_in,
                                         input logic [PAY_W-1:0] din,
                                         input bit feed_line);
    lfsr_res_t r;
    logic [STATE_W-1:0] st;
    logic fb;
    st = st_in;
    r.data = '0;
    for (int i = 0; i < PAY_W; i++) begin
      fb = st[TAP_NEAR] ^ st[TAP_FAR];
      r.data[i] = din[i] ^ fb;
      st = {st[STATE_W-2:0], (feed_line ? din[i] : r.data[i])};
    end
    r.state = st;
    return r;
  endfunction

  // History expected after a full payload: newest bit (payload bit 63) in
  // position 0, then walking back in time.
  function automatic logic [STATE_W-1:0] tail_history(input logic [PAY_W-1:0] line);
    logic [STATE_W-1:0] h;
    for (int k = 0; k < STATE_W; k++) h[k] = line[PAY_W-1-k];
    return h;
  endfunction
endpackage

// File: rtl/blk66_scr_lane.sv
module blk66_scr_lane
  import blk66_scr_pkg::*;
#(
  parameter bit DESCRAMBLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             valid_o,
  output logic [BLK_W-1:0] blk_o
);
  logic [STATE_W-1:0] state_q;
  logic [PAY_W-1:0]   pay_in;
  logic [HDR_W-1:0]   hdr_in;
  lfsr_res_t          step;
  logic               adv_w;
  logic [PAY_W-1:0]   line_bits_w;

  assign pay_in = blk_i[PAY_W-1:0];
  assign hdr_in = blk_i[BLK_W-1:PAY_W];
  assign adv_w  = valid_i;

  generate
    if (DESCRAMBLE) begin : g_rx
      assign step        = lfsr_run(state_q, pay_in, 1'b1);
      assign line_bits_w = pay_in;
    end else begin : g_tx
      assign step        = lfsr_run(state_q, pay_in, 1'b0);
      assign line_bits_w = step.data;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '1;
      valid_o <= 1'b0;
      blk_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (adv_w) begin
        state_q <= step.state;
        blk_o   <= {hdr_in, step.data};
      end
    end
  end

  a_r2_hdr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> blk_o[BLK_W-1:PAY_W] == $past(blk_i[BLK_W-1:PAY_W]));

  a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o == $past(valid_i));

  a_r6_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(state_q));

  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(blk_o));

  generate
    if (DESCRAMBLE) begin : g_rx_chk
      // R4/R7: history holds exactly the last received line bits
      a_r7_hist_from_line: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> state_q == tail_history($past(blk_i[PAY_W-1:0])));
    end else begin : g_tx_chk
      // R3: history holds exactly the last scrambled bits sent
      a_r3_hist_from_out: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> state_q == tail_history(blk_o[PAY_W-1:0]));
    end
  endgenerate
endmodule

// File: rtl/blk66_scrambler_pair.sv
module blk66_scrambler_pair
  import blk66_scr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid_i,
  input  logic [BLK_W-1:0] tx_block_i,
  output logic             tx_valid_o,
  output logic [BLK_W-1:0] tx_block_o,
  input  logic             rx_valid_i,
  input  logic [BLK_W-1:0] rx_block_i,
  output logic             rx_valid_o,
  output logic [BLK_W-1:0] rx_block_o
);
  blk66_scr_lane #(.DESCRAMBLE(1'b0)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .valid_i(tx_valid_i), .blk_i(tx_block_i),
    .valid_o(tx_valid_o), .blk_o(tx_block_o)
  );

  blk66_scr_lane #(.DESCRAMBLE(1'b1)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .valid_i(rx_valid_i), .blk_i(rx_block_i),
    .valid_o(rx_valid_o), .blk_o(rx_block_o)
  );

  // R1: nothing is emitted in the first cycle after reset
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!tx_valid_o && !rx_valid_o));
endmodule

// File: tb/tb_blk66_scrambler_pair.sv
module tb_blk66_scrambler_pair;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_valid_i, rx_valid_i;
  logic [65:0] tx_block_i, rx_block_i;
  logic        tx_valid_o, rx_valid_o;
  logic [65:0] tx_block_o, rx_block_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  blk66_scrambler_pair dut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid_i(tx_valid_i), .tx_block_i(tx_block_i),
    .tx_valid_o(tx_valid_o), .tx_block_o(tx_block_o),
    .rx_valid_i(rx_valid_i), .rx_block_i(rx_block_i),
    .rx_valid_o(rx_valid_o), .rx_block_o(rx_block_o)
  );

  // Bit-serial reference: histories as long sequences, index 0..57 are the
  // all-ones pre-history.
  logic tx_h [0:4095];
  logic rx_h [0:4095];
  int   tx_n, rx_n;

  task automatic model_reset();
    for (int i = 0; i < 58; i++) begin tx_h[i] = 1'b1; rx_h[i] = 1'b1; end
    tx_n = 58; rx_n = 58;
  endtask

  task automatic model_scr(input logic [63:0] d, output logic [63:0] c);
    for (int i = 0; i < 64; i++) begin
      c[i] = d[i] ^ tx_h[tx_n-39] ^ tx_h[tx_n-58];
      tx_h[tx_n] = c[i];
      tx_n++;
    end
  endtask

  task automatic model_dsc(input logic [63:0] r, output logic [63:0] p);
    for (int i = 0; i < 64; i++) begin
      p[i] = r[i] ^ rx_h[rx_n-39] ^ rx_h[rx_n-58];
      rx_h[rx_n] = r[i];
      rx_n++;
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [65:0] act,
                       input logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tx_valid_i = 1'b0; rx_valid_i = 1'b0;
    tx_block_i = '0;   rx_block_i = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic send(input logic tv, input logic [65:0] tb,
                      input logic rv, input logic [65:0] rb);
    @(negedge clk);
    tx_valid_i = tv; tx_block_i = tb;
    rx_valid_i = rv; rx_block_i = rb;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check(tx_valid_o == 1'b0, "R1 tx valid in reset", {65'b0, tx_valid_o}, 66'b0);
    check(tx_block_o == '0, "R1 tx block in reset", tx_block_o, 66'b0);
    @(posedge clk); #1;
    check(rx_valid_o == 1'b0, "R1 rx valid after reset", {65'b0, rx_valid_o}, 66'b0);
    check(rx_block_o == '0, "R1 rx block after reset", rx_block_o, 66'b0);
  endtask

  task automatic t_scramble();
    logic [63:0] pats [4];
    logic [63:0] c;
    logic [1:0]  h;
    pats[0] = 64'h0;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'hA5A5_5A5A_0F0F_F0F0;
    pats[3] = 64'h0123_4567_89AB_CDEF;
    do_reset();
    for (int k = 0; k < 4; k++) begin
      h = k[0] ? 2'b10 : 2'b01;
      model_scr(pats[k], c);
      send(1'b1, {h, pats[k]}, 1'b0, '0);
      check(tx_block_o[63:0] == c, "R3 scrambled payload", tx_block_o, {h, c});
      check(tx_block_o[65:64] == h, "R2 tx header", tx_block_o, {h, c});
      check(tx_valid_o == 1'b1, "R5 tx valid follows", {65'b0, tx_valid_o}, 66'b1);
    end
    send(1'b0, '0, 1'b0, '0);
    check(tx_valid_o == 1'b0, "R5 tx valid drops", {65'b0, tx_valid_o}, 66'b0);
  endtask

  task automatic t_gap();
    logic [63:0] c;
    logic [65:0] held;
    do_reset();
    model_scr(64'hDEAD_BEEF_0000_1111, c);
    send(1'b1, {2'b01, 64'hDEAD_BEEF_0000_1111}, 1'b0, '0);
    held = tx_block_o;
    for (int k = 0; k < 3; k++) begin
      send(1'b0, {2'b10, 64'h5555_AAAA_1234_9876 + 64'(k)}, 1'b0, '0);
      check(tx_block_o == held, "R9 output held while idle", tx_block_o, held);
    end
    model_scr(64'h1357_9BDF_2468_ACE0, c);
    send(1'b1, {2'b10, 64'h1357_9BDF_2468_ACE0}, 1'b0, '0);
    check(tx_block_o == {2'b10, c}, "R6 no advance on idle", tx_block_o, {2'b10, c});
  endtask

  task automatic t_descramble();
    logic [63:0] p, c, q;
    do_reset();
    for (int k = 0; k < 4; k++) begin
      p = {32'hC0FF_EE00 ^ 32'(k * 7919), 32'(k) * 32'h0101_0101};
      model_scr(p, c);
      model_dsc(c, q);
      send(1'b1, {2'b01, p}, 1'b1, {2'b10, c});
      check(rx_block_o == {2'b10, q}, "R4 recovered payload model", rx_block_o, {2'b10, q});
      check(rx_block_o[63:0] == p, "R4 loopback plain payload", rx_block_o, {2'b10, p});
      check(tx_block_o[63:0] == c, "R3 loopback scrambled payload", tx_block_o, {2'b01, c});
    end
  endtask

  task automatic t_selfsync();
    logic [63:0] c0, c1, c2, p2;
    do_reset();
    p2 = 64'hFACE_CAFE_8BAD_F00D;
    model_scr(64'h1111_2222_3333_4444, c0);
    model_scr(64'h9999_0000_7777_6666, c1);
    model_scr(p2, c2);
    send(1'b0, '0, 1'b1, {2'b01, c1});
    check(rx_valid_o == 1'b1, "R5 rx valid follows", {65'b0, rx_valid_o}, 66'b1);
    send(1'b0, '0, 1'b1, {2'b01, c2});
    check(rx_block_o[63:0] == p2, "R7 self-sync recovery", rx_block_o, {2'b01, p2});
  endtask

  task automatic t_error();
    logic [63:0] p0, p1, c0, c1, m0, m1;
    do_reset();
    p0 = 64'h0F1E_2D3C_4B5A_6978;
    p1 = 64'h8796_A5B4_C3D2_E1F0;
    model_scr(p0, c0);
    model_scr(p1, c1);
    send(1'b0, '0, 1'b1, {2'b01, c0 ^ (64'd1 << 10)});
    m0 = rx_block_o[63:0] ^ p0;
    check(m0 == ((64'd1 << 10) | (64'd1 << 49)), "R8 errors in hit block",
          {2'b0, m0}, {2'b0, (64'd1 << 10) | (64'd1 << 49)});
    send(1'b0, '0, 1'b1, {2'b01, c1});
    m1 = rx_block_o[63:0] ^ p1;
    check(m1 == (64'd1 << 4), "R8 error in next block", {2'b0, m1}, {2'b0, 64'd1 << 4});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_scramble();
    t_gap();
    t_descramble();
    t_selfsync();
    t_error();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule